// File: doc/BRIEF.md
# Gated Debug Access Splitter

This block sits between a debug access master that speaks AHB-Lite and the debug slave port of a processor. It decodes each address phase into one of three destinations: the processor's debug port, a 4 KB window served by an APB4 peripheral behind a single-clock bridge, or an internal error responder. An authentication input decides whether traffic aimed at the processor may pass. Blocked processor traffic and any non-word access to the peripheral window go to the error responder, which ends them with a standard AHB ERROR.

The upstream interface follows the AHB handshake. An address phase is accepted on a rising edge where `s_hready` is high. The data phase then lasts until the first rising edge where `s_hready` is high again. While `s_hready` is low, the master must hold `s_hwdata` and present no new address phase. On the APB side, `pready` applies back-pressure: every cycle it stays low adds one wait state upstream. All logic runs on one clock.

Top module: `dbg_split`

## Requirements
- R1: When `debug_en` is high, a transfer outside the peripheral window goes to the processor port with `m_hsel` high. A word transfer (`s_hsize` = 3'b010) whose `s_haddr[31:12]` equals the window base reaches the APB bridge, whatever the state of `debug_en`.
- R2: When `debug_en` is low, a NONSEQ or SEQ transfer (`s_htrans[1]` = 1) outside the window keeps `m_hsel` low and ends in a two-cycle ERROR.
- R3: A transfer into the window with `s_hsize` other than 3'b010 starts no APB cycle and ends in a two-cycle ERROR.
- R4: IDLE (2'b00) and BUSY (2'b01) transfers that the error responder receives get a zero-wait OKAY (`s_hresp` = 0). After reset the block shows `s_hready` = 1, `s_hresp` = 0 and no APB cycle.
- R5: An ERROR response has two cycles. In the first, `s_hready` = 0 and `s_hresp` = 1. In the second, `s_hready` = 1 and `s_hresp` = 1.
- R6: An accepted window transfer produces exactly one SETUP cycle (`psel` = 1, `penable` = 0). ACCESS cycles follow (`psel` = 1, `penable` = 1) up to and including the cycle where `pready` is high. During the transfer `paddr` equals the accepted `s_haddr[11:0]` and `pwrite` equals the accepted `s_hwrite`.
- R7: `s_hready` stays low for the whole APB transfer. It rises in the ACCESS cycle where `pready` is high, with OKAY and `s_hrdata` equal to `prdata`.
- R8: `pslverr` high together with `pready` turns into a two-cycle ERROR. The first ERROR cycle is that same ACCESS cycle.
- R9: During a data phase, `s_hready`, `s_hresp` and `s_hrdata` come from the slave chosen in its address phase, until `s_hready` goes high.
- R10: A change on `debug_en` during a data phase does not alter that transfer. It applies from the next address phase.
- R11: `m_haddr`, `m_hprot` and `m_hwdata` equal their upstream counterparts. `pwdata` equals `s_hwdata`. `pstrb` is 4'b1111 for window writes and 4'b0000 for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| debug_en | input | 1 | Authentication: 1 opens the processor path |
| s_haddr | input | 32 | Upstream address |
| s_htrans | input | 2 | Upstream transfer type |
| s_hwrite | input | 1 | Upstream write flag |
| s_hsize | input | 3 | Upstream transfer size |
| s_hprot | input | 4 | Upstream protection attributes |
| s_hwdata | input | 32 | Upstream write data |
| s_hrdata | output | 32 | Read data to the master |
| s_hready | output | 1 | Transfer done / accept strobe to the master |
| s_hresp | output | 1 | 1 = ERROR |
| m_hsel | output | 1 | Processor port select |
| m_haddr | output | 32 | Processor port address |
| m_htrans | output | 2 | Processor port transfer type |
| m_hwrite | output | 1 | Processor port write flag |
| m_hsize | output | 3 | Processor port size |
| m_hprot | output | 4 | Processor port protection |
| m_hwdata | output | 32 | Processor port write data |
| m_hready | output | 1 | Combined ready into the processor port |
| m_hrdata | input | 32 | Processor port read data |
| m_hreadyout | input | 1 | Processor port ready |
| m_hresp | input | 1 | Processor port response |
| paddr | output | 12 | APB address inside the window |
| psel | output | 1 | APB select |
| penable | output | 1 | APB enable |
| pwrite | output | 1 | APB write flag |
| pwdata | output | 32 | APB write data |
| pstrb | output | 4 | APB byte strobes |
| prdata | input | 32 | APB read data |
| pready | input | 1 | APB ready |
| pslverr | input | 1 | APB slave error |

## Verification
The assertions check the following on every cycle:
- the two-cycle shape of every ERROR, whether it comes from the error responder or from `pslverr`;
- the zero-wait OKAY for IDLE and BUSY;
- the SETUP-then-ACCESS order and the stability of `paddr` while `pready` is low;
- `s_hready` held low during an APB transfer;
- the gate keeping `m_hsel` low for blocked or narrow transfers.

Only the bench scenarios can show the data-phase properties. These are that read data and wait states really come from the slave chosen in the address phase, and that flipping `debug_en` in the middle of a stalled processor transfer leaves that transfer intact while the next one is refused. The same holds for checks at the ports, such as `pstrb` per direction and pass-through of `s_hprot`.

// File: rtl/dsplit_pkg.sv
package dsplit_pkg;
  typedef enum logic [1:0] {
    TGT_CORE   = 2'd0,
    TGT_PERIPH = 2'd1,
    TGT_FAULT  = 2'd2
  } tgt_e;

  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_BUSY   = 2'b01;
  localparam logic [1:0] TR_NONSEQ = 2'b10;
  localparam logic [2:0] SZ_WORD   = 3'b010;
endpackage

// File: rtl/dsplit_route.sv
module dsplit_route
  import dsplit_pkg::*;
#(
  parameter int AW       = 32,
  parameter int WIN_BITS = 12,
  parameter logic [AW-1:0] WIN_BASE = 32'hF000_0000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:WIN_BITS] addr_tag,
  input  logic [2:0]           hsize,
  input  logic                 debug_en,
  input  logic                 hready,
  output tgt_e                 addr_tgt,
  output tgt_e                 data_tgt
);
  logic win_hit;
  assign win_hit = (addr_tag == WIN_BASE[AW-1:WIN_BITS]);

  always_comb begin
    if (win_hit)
      addr_tgt = (hsize == SZ_WORD) ? TGT_PERIPH : TGT_FAULT;
    else
      addr_tgt = debug_en ? TGT_CORE : TGT_FAULT;
  end

  // data-phase owner follows the address phase only when the bus advances
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_tgt <= TGT_FAULT;
    else if (hready) data_tgt <= addr_tgt;
  end

  AST_OWNER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !hready |=> (data_tgt == $past(data_tgt))); // R9
endmodule

// File: rtl/dsplit_fault.sv
module dsplit_fault (
  input  logic clk,
  input  logic rst_n,
  input  logic hsel,
  input  logic xfer_active,
  input  logic hready,
  output logic hreadyout,
  output logic hresp
);
  logic err_first, err_second;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_first  <= 1'b0;
      err_second <= 1'b0;
    end else begin
      err_first  <= hsel & hready & xfer_active;
      err_second <= err_first;
    end
  end

  assign hreadyout = ~err_first;
  assign hresp     = err_first | err_second;

  AST_ERR_START: assert property (@(posedge clk) disable iff (!rst_n)
    (hsel && hready && xfer_active) |=> (!hreadyout && hresp)); // R5
  AST_ERR_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    (!hreadyout && hresp) |=> (hreadyout && hresp)); // R5
  AST_IDLE_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
    (hsel && hready && !xfer_active) |=> (hreadyout && !hresp)); // R4
endmodule

// File: rtl/dsplit_apb_bridge.sv
module dsplit_apb_bridge #(
  parameter int DW  = 32,
  parameter int PAW = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hsel,
  input  logic            xfer_active,
  input  logic            hready,
  input  logic [PAW-1:0]  haddr,
  input  logic            hwrite,
  input  logic [DW-1:0]   hwdata,
  output logic [DW-1:0]   hrdata,
  output logic            hreadyout,
  output logic            hresp,
  output logic [PAW-1:0]  paddr,
  output logic            psel,
  output logic            penable,
  output logic            pwrite,
  output logic [DW-1:0]   pwdata,
  output logic [DW/8-1:0] pstrb,
  input  logic [DW-1:0]   prdata,
  input  logic            pready,
  input  logic            pslverr
);
  localparam int SW = DW / 8;

  typedef enum logic [1:0] {B_IDLE, B_SETUP, B_ACCESS, B_ERR} bstate_e;
  bstate_e        state;
  logic [PAW-1:0] lat_addr;
  logic           lat_write;
  logic           start;

  assign start = hsel & hready & xfer_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= B_IDLE;
      lat_addr  <= '0;
      lat_write <= 1'b0;
    end else begin
      case (state)
        B_SETUP:  state <= B_ACCESS;
        B_ACCESS: begin
          if (pready) begin
            if (pslverr) state <= B_ERR;
            else if (start) begin
              state     <= B_SETUP;
              lat_addr  <= haddr;
              lat_write <= hwrite;
            end else state <= B_IDLE;
          end
        end
        default: begin
          if (start) begin
            state     <= B_SETUP;
            lat_addr  <= haddr;
            lat_write <= hwrite;
          end else state <= B_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    case (state)
      B_SETUP:  begin hreadyout = 1'b0;               hresp = 1'b0;             end
      B_ACCESS: begin hreadyout = pready & ~pslverr;  hresp = pready & pslverr; end
      B_ERR:    begin hreadyout = 1'b1;               hresp = 1'b1;             end
      default:  begin hreadyout = 1'b1;               hresp = 1'b0;             end
    endcase
  end

  assign psel    = (state == B_SETUP) || (state == B_ACCESS);
  assign penable = (state == B_ACCESS);
  assign paddr   = lat_addr;
  assign pwrite  = lat_write;
  assign pwdata  = hwdata;
  assign pstrb   = {SW{lat_write}};
  assign hrdata  = prdata;

  AST_SETUP_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !penable) |=> (psel && penable)); // R6
  AST_ACCESS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && !pready) |=> (psel && penable && $stable(paddr) && $stable(pwrite))); // R6
  AST_STALL_UPSTREAM: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !(penable && pready)) |-> !hreadyout); // R7
  AST_SLVERR_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pready && pslverr) |-> (!hreadyout && hresp)); // R8
  AST_SLVERR_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && penable && pready && pslverr) |=> (hreadyout && hresp && !psel)); // R8
endmodule

// File: rtl/dbg_split.sv
module dbg_split
  import dsplit_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int WIN_BITS = 12,
  parameter logic [AW-1:0] WIN_BASE = 32'hF000_0000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 debug_en,
  input  logic [AW-1:0]        s_haddr,
  input  logic [1:0]           s_htrans,
  input  logic                 s_hwrite,
  input  logic [2:0]           s_hsize,
  input  logic [3:0]           s_hprot,
  input  logic [DW-1:0]        s_hwdata,
  output logic [DW-1:0]        s_hrdata,
  output logic                 s_hready,
  output logic                 s_hresp,
  output logic                 m_hsel,
  output logic [AW-1:0]        m_haddr,
  output logic [1:0]           m_htrans,
  output logic                 m_hwrite,
  output logic [2:0]           m_hsize,
  output logic [3:0]           m_hprot,
  output logic [DW-1:0]        m_hwdata,
  output logic                 m_hready,
  input  logic [DW-1:0]        m_hrdata,
  input  logic                 m_hreadyout,
  input  logic                 m_hresp,
  output logic [WIN_BITS-1:0]  paddr,
  output logic                 psel,
  output logic                 penable,
  output logic                 pwrite,
  output logic [DW-1:0]        pwdata,
  output logic [DW/8-1:0]      pstrb,
  input  logic [DW-1:0]        prdata,
  input  logic                 pready,
  input  logic                 pslverr
);
  tgt_e          addr_tgt, data_tgt;
  logic          br_ready, br_resp, ft_ready, ft_resp;
  logic [DW-1:0] br_rdata;

  dsplit_route #(.AW(AW), .WIN_BITS(WIN_BITS), .WIN_BASE(WIN_BASE)) u_route (
    .clk(clk), .rst_n(rst_n), .addr_tag(s_haddr[AW-1:WIN_BITS]), .hsize(s_hsize),
    .debug_en(debug_en), .hready(s_hready), .addr_tgt(addr_tgt), .data_tgt(data_tgt)
  );

  dsplit_fault u_fault (
    .clk(clk), .rst_n(rst_n), .hsel(addr_tgt == TGT_FAULT), .xfer_active(s_htrans[1]),
    .hready(s_hready), .hreadyout(ft_ready), .hresp(ft_resp)
  );

  dsplit_apb_bridge #(.DW(DW), .PAW(WIN_BITS)) u_bridge (
    .clk(clk), .rst_n(rst_n), .hsel(addr_tgt == TGT_PERIPH), .xfer_active(s_htrans[1]),
    .hready(s_hready), .haddr(s_haddr[WIN_BITS-1:0]), .hwrite(s_hwrite), .hwdata(s_hwdata),
    .hrdata(br_rdata), .hreadyout(br_ready), .hresp(br_resp),
    .paddr(paddr), .psel(psel), .penable(penable), .pwrite(pwrite), .pwdata(pwdata),
    .pstrb(pstrb), .prdata(prdata), .pready(pready), .pslverr(pslverr)
  );

  // processor port: address phase straight through, select gated by decode
  assign m_hsel   = (addr_tgt == TGT_CORE);
  assign m_haddr  = s_haddr;
  assign m_htrans = s_htrans;
  assign m_hwrite = s_hwrite;
  assign m_hsize  = s_hsize;
  assign m_hprot  = s_hprot;
  assign m_hwdata = s_hwdata;
  assign m_hready = s_hready;

  // data-phase response multiplexer
  always_comb begin
    case (data_tgt)
      TGT_CORE:   begin s_hready = m_hreadyout; s_hresp = m_hresp; s_hrdata = m_hrdata; end
      TGT_PERIPH: begin s_hready = br_ready;    s_hresp = br_resp; s_hrdata = br_rdata; end
      default:    begin s_hready = ft_ready;    s_hresp = ft_resp; s_hrdata = '0;       end
    endcase
  end

  logic in_win;
  assign in_win = (s_haddr[AW-1:WIN_BITS] == WIN_BASE[AW-1:WIN_BITS]);

  AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_win && !debug_en) |-> !m_hsel); // R2
  AST_GATE_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    (s_hready && s_htrans[1] && !in_win && !debug_en) |=> (!s_hready && s_hresp)); // R2
  AST_NARROW_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (s_hready && s_htrans[1] && in_win && s_hsize != SZ_WORD) |=> (!psel && !s_hready && s_hresp)); // R3
  AST_WORD_TO_APB: assert property (@(posedge clk) disable iff (!rst_n)
    (s_hready && s_htrans[1] && in_win && s_hsize == SZ_WORD) |=> (psel && !penable)); // R1
endmodule

// File: tb/test_dbg_split.sv
module test_dbg_split;
  localparam logic [31:0] WBASE = 32'hF000_0000;

  logic        clk = 1'b0, rst_n = 1'b0, debug_en = 1'b1;
  logic [31:0] s_haddr = '0, s_hwdata = '0, s_hrdata;
  logic [1:0]  s_htrans = 2'b00;
  logic        s_hwrite = 1'b0, s_hready, s_hresp;
  logic [2:0]  s_hsize = 3'b010;
  logic [3:0]  s_hprot = 4'hB;
  logic        m_hsel, m_hwrite, m_hready;
  logic [31:0] m_haddr, m_hwdata, m_hrdata = '0;
  logic [1:0]  m_htrans;
  logic [2:0]  m_hsize;
  logic [3:0]  m_hprot;
  logic        m_hreadyout = 1'b1, m_hresp = 1'b0;
  logic [11:0] paddr;
  logic        psel, penable, pwrite;
  logic [31:0] pwdata, prdata = '0;
  logic [3:0]  pstrb;
  logic        pready = 1'b0, pslverr = 1'b0;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  dbg_split #(.WIN_BASE(WBASE)) i_dbg_split (
    .clk(clk), .rst_n(rst_n), .debug_en(debug_en),
    .s_haddr(s_haddr), .s_htrans(s_htrans), .s_hwrite(s_hwrite), .s_hsize(s_hsize),
    .s_hprot(s_hprot), .s_hwdata(s_hwdata), .s_hrdata(s_hrdata), .s_hready(s_hready),
    .s_hresp(s_hresp), .m_hsel(m_hsel), .m_haddr(m_haddr), .m_htrans(m_htrans),
    .m_hwrite(m_hwrite), .m_hsize(m_hsize), .m_hprot(m_hprot), .m_hwdata(m_hwdata),
    .m_hready(m_hready), .m_hrdata(m_hrdata), .m_hreadyout(m_hreadyout), .m_hresp(m_hresp),
    .paddr(paddr), .psel(psel), .penable(penable), .pwrite(pwrite), .pwdata(pwdata),
    .pstrb(pstrb), .prdata(prdata), .pready(pready), .pslverr(pslverr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Reference model of one transfer: kind 0 = processor, 1 = APB window, 2 = error responder.
  // Each expected value below comes from the requirements, cycle by cycle.
  task automatic xfer(input logic [31:0] a, input logic [2:0] sz, input bit wr,
                      input logic [31:0] wd, input int kind, input int waits,
                      input bit slverr, input bit flip_auth, input string req);
    logic [31:0] rd;
    @(negedge clk);
    pready = 1'b0; pslverr = 1'b0; m_hreadyout = 1'b1;
    s_haddr = a; s_htrans = 2'b10; s_hsize = sz; s_hwrite = wr; s_hprot = 4'hB ^ a[3:0];
    #2;
    chk(m_hsel == (kind == 0), req, "m_hsel in address phase", {31'd0, m_hsel}, {31'd0, kind == 0});
    if (kind == 0)
      chk(m_haddr == a && m_hprot == (4'hB ^ a[3:0]), "R11", "address/prot pass-through",
          {m_hprot, m_haddr[27:0]}, {4'hB ^ a[3:0], a[27:0]});
    @(negedge clk);
    s_htrans = 2'b00; s_hwdata = wd;
    if (kind == 0) begin
      rd = 32'hC0DE_0000 ^ a;
      m_hrdata = rd;
      for (int i = 0; i <= waits; i++) begin
        if (i > 0) @(negedge clk);
        m_hreadyout = (i == waits);
        if (flip_auth && i == 0) debug_en = ~debug_en;
        #2;
        chk(s_hready == (i == waits), flip_auth ? "R10" : "R9", "core wait state follows port",
            {31'd0, s_hready}, {31'd0, i == waits});
        chk(m_hwdata == wd, "R11", "hwdata pass-through", m_hwdata, wd);
        if (i == waits) begin
          chk(s_hrdata == rd && !s_hresp, flip_auth ? "R10" : "R9", "core read data and OKAY",
              s_hrdata, rd);
        end
      end
    end else if (kind == 1) begin
      rd = 32'h5A5A_0000 ^ a;
      prdata = rd;
      #2;
      chk(psel && !penable, "R6", "SETUP cycle", {30'd0, psel, penable}, 32'h2);
      chk(!s_hready, "R7", "stall during SETUP", {31'd0, s_hready}, 32'd0);
      chk(paddr == a[11:0] && pwrite == wr, "R6", "paddr/pwrite", {19'd0, pwrite, paddr},
          {19'd0, wr, a[11:0]});
      chk(pstrb == (wr ? 4'hF : 4'h0) && pwdata == wd, "R11", "pstrb/pwdata", {28'd0, pstrb},
          {28'd0, wr ? 4'hF : 4'h0});
      for (int i = 0; i <= waits; i++) begin
        @(negedge clk);
        pready  = (i == waits);
        pslverr = slverr && (i == waits);
        #2;
        chk(psel && penable && paddr == a[11:0], "R6", "ACCESS cycle",
            {30'd0, psel, penable}, 32'h3);
        if (i < waits)
          chk(!s_hready, "R7", "stall while pready low", {31'd0, s_hready}, 32'd0);
        else if (!slverr)
          chk(s_hready && !s_hresp && s_hrdata == rd, "R7", "APB completion data", s_hrdata, rd);
        else
          chk(!s_hready && s_hresp, "R8", "slverr first ERROR cycle",
              {30'd0, s_hready, s_hresp}, 32'h1);
      end
      if (slverr) begin
        @(negedge clk);
        pready = 1'b0; pslverr = 1'b0;
        #2;
        chk(s_hready && s_hresp && !psel, "R8", "slverr second ERROR cycle",
            {30'd0, s_hready, s_hresp}, 32'h3);
      end
    end else begin
      #2;
      chk(!s_hready && s_hresp && !psel && !m_hsel, req, "first ERROR cycle",
          {29'd0, psel, s_hready, s_hresp}, 32'h1);
      @(negedge clk);
      #2;
      chk(s_hready && s_hresp && !psel, "R5", "second ERROR cycle",
          {29'd0, psel, s_hready, s_hresp}, 32'h3);
    end
  endtask

  task automatic idle_xfer(input logic [1:0] tr, input logic [31:0] a);
    @(negedge clk);
    pready = 1'b0; pslverr = 1'b0;
    s_htrans = tr; s_haddr = a; s_hsize = 3'b010;
    @(negedge clk);
    s_htrans = 2'b00;
    #2;
    chk(s_hready && !s_hresp && !psel, "R4", "zero-wait OKAY for IDLE/BUSY",
        {29'd0, psel, s_hready, s_hresp}, 32'h2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL all-requirements watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk(s_hready && !s_hresp && !psel && !penable, "R4", "reset state",
        {29'd0, psel, s_hready, s_hresp}, 32'h2);
    // open gate: processor and APB paths
    xfer(32'h2000_0010, 3'b010, 1'b0, 32'h0,          0, 0, 1'b0, 1'b0, "R1");
    xfer(32'h2000_0024, 3'b010, 1'b1, 32'h1234_5678,  0, 2, 1'b0, 1'b0, "R1");
    xfer(WBASE | 32'h004, 3'b010, 1'b1, 32'hAABB_CCDD, 1, 0, 1'b0, 1'b0, "R1");
    xfer(WBASE | 32'hFFC, 3'b010, 1'b0, 32'h0,         1, 3, 1'b0, 1'b0, "R1");
    xfer(WBASE | 32'h100, 3'b010, 1'b1, 32'h0BAD_F00D, 1, 1, 1'b1, 1'b0, "R8");
    xfer(WBASE | 32'h200, 3'b010, 1'b1, 32'h1111_2222, 1, 0, 1'b0, 1'b0, "R7");
    // narrow accesses into the window
    xfer(WBASE | 32'h008, 3'b001, 1'b1, 32'h0, 2, 0, 1'b0, 1'b0, "R3");
    xfer(WBASE | 32'h00B, 3'b000, 1'b0, 32'h0, 2, 0, 1'b0, 1'b0, "R3");
    // authentication drops mid-transfer: current one completes, next is refused
    xfer(32'h2000_0040, 3'b010, 1'b0, 32'h0, 0, 2, 1'b0, 1'b1, "R10");
    xfer(32'h2000_0044, 3'b010, 1'b0, 32'h0, 2, 0, 1'b0, 1'b0, "R2");
    xfer(32'hE000_EDF0, 3'b010, 1'b1, 32'h5, 2, 0, 1'b0, 1'b0, "R2");
    xfer(WBASE | 32'h010, 3'b010, 1'b1, 32'hCAFE_0001, 1, 1, 1'b0, 1'b0, "R1");
    idle_xfer(2'b00, 32'h2000_0000);
    idle_xfer(2'b01, 32'h2000_0004);
    // gate reopened
    @(negedge clk);
    debug_en = 1'b1;
    xfer(32'h2000_0080, 3'b001, 1'b1, 32'h7777_8888, 0, 1, 1'b0, 1'b0, "R1");
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule